// File: doc/BRIEF.md
# Glitchless Pin-Selected Frequency Switch

This block drives six clock outputs. Each output has its own pair of source clocks, a first-frequency clock and a second-frequency clock, and passes exactly one of them at a time. Two asynchronous select pins decide which source each output uses. A link map decides which outputs follow which pin. One pin can steer any group of outputs, and the other pin can steer any other group.

When the select that governs an output changes, the output finishes its current cycle on the old source. It then stays low while the change crosses into the new clock domain, and it resumes on a full leading edge of the new source. No shortened pulse or shortened gap reaches the output. Each output has its own handover circuit, so a change only disturbs the outputs linked to the pin that moved.

Top module: `clk_fs_switch`

## Requirements
- R1: While `rst_n` is low every bit of `clk_out` is 0. After `rst_n` rises with both pins at 0, every output runs at the period of its `clk_a` source.
- R2: `link_map[i]` links output i to pin 0 and `link_map[N_OUT+i]` links it to pin 1. If both bits are set, pin 0 governs the output. If neither bit is set, the output stays on `clk_a` whatever the pins do.
- R3: A governing select level of 0 routes `clk_a[i]` to `clk_out[i]`, and a level of 1 routes `clk_b[i]`.
- R4: Every high pulse on an output lasts exactly one high phase of one of its sources, and every low phase lasts at least half the shorter source period. The two source enables of an output are never high together. An enable never changes while its own clock is high.
- R5: The old source is released on its own falling edge. The new source is enabled on its own falling edge, and only after the request has passed a two-flop synchronizer clocked by the new source. The switch settles within 12 periods of the slower source. This holds provided the governing select level stays put for at least 8 periods of the slower source.
- R6: An output whose governing pin does not change keeps its exact period, with no interruption, while other outputs switch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_a | input | N_OUT | First-frequency source clock for each output |
| clk_b | input | N_OUT | Second-frequency source clock for each output |
| fs_pin | input | 2 | Asynchronous frequency-select pins |
| link_map | input | 2*N_OUT | Bits [N_OUT-1:0] link outputs to pin 0; bits [2*N_OUT-1:N_OUT] link them to pin 1 |
| clk_out | output | N_OUT | Switched output clocks |

## Verification
The assertions check the following on every edge of each source clock:
- the two enables of an output are mutually exclusive;
- neither enable moves during its clock's high phase;
- an enable rises only when the decoded select, two edges earlier in that domain, asked for it;
- the new enable rises only while the old one is low.

Only the bench scenarios can show the remaining behaviour, because it depends on measured periods and pulse widths at the pins:
- the mapping and priority rules;
- that each output settles onto the correct period within the stated bound;
- that unrelated outputs keep their period while others switch.

// File: rtl/clk_fs_switch_pkg.sv
package clk_fs_switch_pkg;

  localparam int unsigned FS_PINS = 2;

  // Decoded select for one output: pin 0 has priority; unlinked -> first source.
  function automatic logic pick_select(input logic link0, input logic link1,
                                       input logic [FS_PINS-1:0] pins);
    if (link0)      return pins[0];
    else if (link1) return pins[1];
    else            return 1'b0;
  endfunction

endpackage

// File: rtl/fs_sync.sv
module fs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clk_handover.sv
module clk_handover #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic rst_n,
  input  logic clk_a,
  input  logic clk_b,
  input  logic sel,
  output logic en_a,
  output logic en_b,
  output logic clk_o
);
  logic req_a, req_b;
  logic req_a_s, req_b_s;

  // Each side may run only when selected and the other side is off.
  assign req_a = ~sel & ~en_b;
  assign req_b =  sel & ~en_a;

  fs_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
    .clk(clk_a), .rst_n(rst_n), .d(req_a), .q(req_a_s)
  );

  fs_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
    .clk(clk_b), .rst_n(rst_n), .d(req_b), .q(req_b_s)
  );

  // Enables move only while their clock is low.
  always_ff @(negedge clk_a or negedge rst_n) begin
    if (!rst_n) en_a <= 1'b0;
    else        en_a <= req_a_s;
  end

  always_ff @(negedge clk_b or negedge rst_n) begin
    if (!rst_n) en_b <= 1'b0;
    else        en_b <= req_b_s;
  end

  assign clk_o = (clk_a & en_a) | (clk_b & en_b);
endmodule

// File: rtl/clk_fs_switch.sv
module clk_fs_switch
  import clk_fs_switch_pkg::*;
#(
  parameter int unsigned N_OUT       = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   rst_n,
  input  logic [N_OUT-1:0]       clk_a,
  input  logic [N_OUT-1:0]       clk_b,
  input  logic [FS_PINS-1:0]     fs_pin,
  input  logic [2*N_OUT-1:0]     link_map,
  output logic [N_OUT-1:0]       clk_out
);
  localparam int unsigned MAP_HI = N_OUT;

  // Named internal events for the checker.
  logic [N_OUT-1:0] sel_eff;
  logic [N_OUT-1:0] en_a_w;
  logic [N_OUT-1:0] en_b_w;

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    assign sel_eff[i] = pick_select(link_map[i], link_map[MAP_HI+i], fs_pin);

    clk_handover #(.SYNC_STAGES(SYNC_STAGES)) u_hand (
      .rst_n (rst_n),
      .clk_a (clk_a[i]),
      .clk_b (clk_b[i]),
      .sel   (sel_eff[i]),
      .en_a  (en_a_w[i]),
      .en_b  (en_b_w[i]),
      .clk_o (clk_out[i])
    );
  end
endmodule

// File: rtl/clk_fs_switch_chk.sv
module clk_fs_switch_chk #(
  parameter int unsigned N_OUT = 6
) (
  input logic             rst_n,
  input logic [N_OUT-1:0] clk_a,
  input logic [N_OUT-1:0] clk_b,
  input logic [N_OUT-1:0] sel_eff,
  input logic [N_OUT-1:0] en_a,
  input logic [N_OUT-1:0] en_b
);
  for (genvar g = 0; g < N_OUT; g++) begin : g_chk
    logic a_at_rise, b_at_rise;

    always_ff @(posedge clk_a[g] or negedge rst_n) begin
      if (!rst_n) a_at_rise <= 1'b0;
      else        a_at_rise <= en_a[g];
    end

    always_ff @(posedge clk_b[g] or negedge rst_n) begin
      if (!rst_n) b_at_rise <= 1'b0;
      else        b_at_rise <= en_b[g];
    end

    AST_EN_EXCL_A: assert property (@(posedge clk_a[g]) disable iff (!rst_n)
      !(en_a[g] && en_b[g]));                                            // R4
    AST_EN_EXCL_B: assert property (@(posedge clk_b[g]) disable iff (!rst_n)
      !(en_a[g] && en_b[g]));                                            // R4
    AST_EN_A_STILL_HIGH: assert property (@(negedge clk_a[g]) disable iff (!rst_n)
      en_a[g] == a_at_rise);                                             // R4
    AST_EN_B_STILL_HIGH: assert property (@(negedge clk_b[g]) disable iff (!rst_n)
      en_b[g] == b_at_rise);                                             // R4
    AST_A_RISE_SYNCED: assert property (@(posedge clk_a[g]) disable iff (!rst_n)
      $rose(en_a[g]) |-> !$past(sel_eff[g], 2));                         // R5
    AST_B_RISE_SYNCED: assert property (@(posedge clk_b[g]) disable iff (!rst_n)
      $rose(en_b[g]) |-> $past(sel_eff[g], 2));                          // R5
    AST_B_AFTER_A_OFF: assert property (@(posedge clk_b[g]) disable iff (!rst_n)
      $rose(en_b[g]) |-> !en_a[g]);                                      // R5
    AST_A_AFTER_B_OFF: assert property (@(posedge clk_a[g]) disable iff (!rst_n)
      $rose(en_a[g]) |-> !en_b[g]);                                      // R5
  end
endmodule

bind clk_fs_switch clk_fs_switch_chk #(.N_OUT(N_OUT)) u_chk (
  .rst_n   (rst_n),
  .clk_a   (clk_a),
  .clk_b   (clk_b),
  .sel_eff (sel_eff),
  .en_a    (en_a_w),
  .en_b    (en_b_w)
);

// File: tb/tb_clk_fs_switch.sv
`timescale 1ns/1ps
module tb_clk_fs_switch;
  localparam int  N           = 6;
  localparam time CLK_PERIOD  = 10;
  localparam time SLOW_PERIOD = 2*CLK_PERIOD + 6;
  localparam time SETTLE      = 12*SLOW_PERIOD;
  localparam time WINDOW      = 10*SLOW_PERIOD;

  logic ca = 1'b0, cb = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] fs = 2'b00;
  logic [2*N-1:0] lmap = '0;
  logic [N-1:0] clk_out;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2)  ca = ~ca;
  always #(SLOW_PERIOD/2) cb = ~cb;

  clk_fs_switch dut (
    .rst_n(rst_n), .clk_a({N{ca}}), .clk_b({N{cb}}),
    .fs_pin(fs), .link_map(lmap), .clk_out(clk_out)
  );

  time pmin [N];
  time pmax [N];
  int  bad_pulse [N];

  for (genvar g = 0; g < N; g++) begin : g_mon
    time t_rise, t_fall;
    bit  seen_rise = 1'b0, seen_fall = 1'b0;
    initial bad_pulse[g] = 0;
    always @(posedge clk_out[g]) begin
      if (seen_rise) begin
        if ($time - t_rise < pmin[g]) pmin[g] = $time - t_rise;
        if ($time - t_rise > pmax[g]) pmax[g] = $time - t_rise;
      end
      if (seen_fall && ($time - t_fall) < CLK_PERIOD/2) bad_pulse[g]++;
      t_rise = $time; seen_rise = 1'b1;
    end
    always @(negedge clk_out[g]) begin
      if (seen_rise) begin
        if (($time - t_rise) != CLK_PERIOD/2 && ($time - t_rise) != SLOW_PERIOD/2)
          bad_pulse[g]++;
        t_fall = $time; seen_fall = 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    for (int i = 0; i < N; i++) begin
      pmin[i] = 64'hFFFF_FFFF_FFFF_FFFF;
      pmax[i] = 0;
    end
  endtask

  // Outputs in slow_mask expect the second-source period, the rest the first.
  task automatic expect_periods(input logic [N-1:0] slow_mask, input string req);
    #(SETTLE);
    clear_stats();
    #(WINDOW);
    for (int i = 0; i < N; i++) begin
      time e = slow_mask[i] ? SLOW_PERIOD : CLK_PERIOD;
      check(pmin[i] == e, req, pmin[i], e);
      check(pmax[i] == e, req, pmax[i], e);
    end
  endtask

  task automatic test_reset();
    for (int k = 0; k < 5; k++) begin
      #7;
      check(clk_out == '0, "R1 reset low", clk_out, 0);
    end
    #2 rst_n = 1'b1;
    expect_periods('0, "R1 first source after reset");
  endtask

  task automatic test_group_pin0();
    lmap = {6'b010110, 6'b101001};
    expect_periods('0, "R3 pins low");
    clear_stats();
    fs[0] = 1'b1;
    #(SETTLE);
    for (int i = 0; i < N; i++)
      if (!lmap[i]) begin
        check(pmin[i] == CLK_PERIOD && pmax[i] == CLK_PERIOD, "R6 unlinked unchanged",
              pmax[i], CLK_PERIOD);
      end
    expect_periods(6'b101001, "R5 R3 pin0 group switched");
  endtask

  task automatic test_group_pin1();
    fs[1] = 1'b1;
    expect_periods(6'b111111, "R3 both groups slow");
    fs[0] = 1'b0;
    expect_periods(6'b010110, "R3 pin0 group back");
    fs[1] = 1'b0;
    expect_periods('0, "R3 all back");
  endtask

  task automatic test_priority();
    lmap = {6'b000011, 6'b000001};
    fs = 2'b10;
    expect_periods(6'b000010, "R2 pin0 priority on out0");
    fs = 2'b01;
    expect_periods(6'b000001, "R2 pin0 priority selects");
    lmap = '0;
    fs = 2'b11;
    expect_periods('0, "R2 unlinked stays first");
    fs = 2'b00;
  endtask

  task automatic test_no_runts();
    lmap = {6'b000000, 6'b111111};
    for (int k = 0; k < 10; k++) begin
      fs[0] = ~fs[0];
      #(SETTLE);
    end
    for (int i = 0; i < N; i++)
      check(bad_pulse[i] == 0, "R4 no runt pulse", bad_pulse[i], 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    clear_stats();
    test_reset();
    test_group_pin0();
    test_group_pin1();
    test_priority();
    test_no_runts();
    done = 1'b1;
    finish_run();
  end

  initial begin
    #(150000*CLK_PERIOD);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end
endmodule